// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power Sequencer

This block sits beside the read/write path of a controller for a single-rank SDR SDRAM with a parameterised number of banks. It owns refresh and the two low-power states. An internal interval counter adds one owed refresh every `T_REFI` cycles and keeps up to `PEND_MAX` of them. It services owed refreshes whenever it is idle. On request it enters and leaves self refresh or power-down. While it does any of this it withdraws the grant from the read/write path and drives the command bus and the clock-enable line itself.

Before any refresh it closes open banks with a precharge-all and waits `T_RP`. After each auto refresh it holds the bus at NOP for `T_RFC`. It surrounds self refresh with bursts of `BURST_LEN` auto refreshes. It classifies each power-down as active or precharge from the bank status it sees when entering. All timings are cycle counts given as parameters.

Top module: `sdram_lp_sequencer`

## Requirements
- R1: When a refresh or self-refresh entry starts with any bit of `bank_open_i` set, a precharge-all (`cmd_o` = 1) is driven first. No auto refresh (`cmd_o` = 2) or self-refresh entry (`cmd_o` = 3) follows it earlier than `T_RP` cycles later, and every auto refresh or self-refresh entry happens with all banks closed.
- R2: After an auto refresh, the next non-NOP command (`cmd_o` = 0 is NOP) comes no sooner than `T_RFC` cycles later.
- R3: A refresh that starts with all banks closed issues no precharge-all, and none follows it.
- R4: From the self-refresh entry cycle until exit, `cke_o` stays low, `cmd_o` is NOP apart from the entry cycle itself, and `sr_active_o` is high.
- R5: After `cke_o` rises on leaving self refresh, the first command comes no earlier than max(`T_RFC`, `T_SS`) cycles later.
- R6: Exactly `BURST_LEN` auto refreshes are issued between a self-refresh request and the entry command, and exactly `BURST_LEN` between exit and the grant returning.
- R7: Power-down drives `cke_o` low. `pd_mode_o` reads 1 (active power-down) if any bank was open on entry and 2 (precharge power-down) if none was. It reads 0 outside power-down.
- R8: After `cke_o` rises on leaving power-down, no command is driven for at least `T_SS` cycles.
- R9: One refresh becomes owed every `T_REFI` cycles, except while held in self refresh. At most `PEND_MAX` are kept, and each owed refresh produces one auto refresh once the block is idle.
- R10: When idle, a self-refresh request takes precedence over an owed refresh, which takes precedence over a power-down request. The grant is given only when none is present.
- R11: After reset, `cmd_o` is NOP, `cke_o` is high and `pd_mode_o` is 0. `grant_o` is low in every cycle that carries a command and in the cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_open_i | input | NUM_BANKS | Per-bank open status from the main controller |
| sr_enter_req_i | input | 1 | Level request to enter self refresh |
| sr_exit_req_i | input | 1 | Request to leave self refresh |
| pd_enter_req_i | input | 1 | Level request to enter power-down |
| pd_exit_req_i | input | 1 | Request to leave power-down |
| cmd_o | output | 2 | Command: 0 NOP, 1 precharge-all, 2 auto refresh, 3 self-refresh entry |
| cke_o | output | 1 | Clock enable to the memory |
| grant_o | output | 1 | Read/write path may issue commands this cycle |
| busy_o | output | 1 | Sequencer is away from its idle state |
| pd_mode_o | output | 2 | 0 none, 1 active power-down, 2 precharge power-down |
| sr_active_o | output | 1 | Self refresh is in force |

## Verification
The assertions take for granted that `bank_open_i` goes to zero once a precharge-all has been driven. They also assume that `T_RP` and `T_RFC` are at least 2 and `T_SS` at least 1, and that the exit requests arrive only while the matching low-power state holds. The bench keeps within these limits. It models bank status itself and clears it on every observed precharge-all. It holds entry requests until `cke_o` falls, and pulses exit requests only after confirming the low-power state. It times each phase against a cycle count since reset, so that interval ticks land where the expected refresh counts allow.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PREA = 2'd1,
    CMD_AREF = 2'd2,
    CMD_SREF = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    PDM_NONE   = 2'd0,
    PDM_ACTIVE = 2'd1,
    PDM_PRECHG = 2'd2
  } pdm_e;

  typedef enum logic [1:0] {
    PUR_REF    = 2'd0,
    PUR_SR_IN  = 2'd1,
    PUR_SR_OUT = 2'd2
  } purpose_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PREP,
    ST_PRE,
    ST_WAIT_RP,
    ST_REF,
    ST_WAIT_RFC,
    ST_SR_ENTER,
    ST_SR_HOLD,
    ST_SR_EXIT,
    ST_PD,
    ST_PD_EXIT
  } state_e;

endpackage

// File: rtl/sdram_lp_downcount.sv
module sdram_lp_downcount #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (dec && (cnt_q != '0))
      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R2
  hold_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

endmodule

// File: rtl/sdram_lp_tracker.sv
module sdram_lp_tracker #(
  parameter int T_REFI   = 1560,
  parameter int PEND_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze,
  input  logic served,
  output logic due
);

  localparam int IW = (T_REFI > 1) ? $clog2(T_REFI) : 1;
  localparam int PW = $clog2(PEND_MAX + 1);

  logic [IW-1:0] ivl_q, ivl_d;
  logic [PW-1:0] pend_q, pend_d;
  logic          tick, full, add, sub;

  assign tick = !freeze && (ivl_q == IW'(T_REFI - 1));
  assign full = (pend_q == PW'(PEND_MAX));
  assign add  = tick && !full;
  assign sub  = served && (pend_q != '0);

  always_comb begin
    ivl_d = ivl_q;
    if (tick)         ivl_d = '0;
    else if (!freeze) ivl_d = ivl_q + IW'(1);
    pend_d = pend_q;
    if (add && !sub)      pend_d = pend_q + PW'(1);
    else if (sub && !add) pend_d = pend_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q  <= '0;
      pend_q <= '0;
    end else begin
      ivl_q  <= ivl_d;
      pend_q <= pend_d;
    end
  end

  assign due = (pend_q != '0);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PW'(PEND_MAX));

  // R9
  due_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(due) |-> $past(served));

endmodule

// File: rtl/sdram_lp_sequencer.sv
module sdram_lp_sequencer
  import sdram_lp_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 9,
  parameter int T_SS      = 2,
  parameter int T_REFI    = 1560,
  parameter int BURST_LEN = 4096,
  parameter int PEND_MAX  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  input  logic                 sr_enter_req_i,
  input  logic                 sr_exit_req_i,
  input  logic                 pd_enter_req_i,
  input  logic                 pd_exit_req_i,
  output logic [1:0]           cmd_o,
  output logic                 cke_o,
  output logic                 grant_o,
  output logic                 busy_o,
  output logic [1:0]           pd_mode_o,
  output logic                 sr_active_o
);

  localparam int EXIT_WAIT = (T_RFC > T_SS) ? T_RFC : T_SS;
  localparam int TMAX1     = (T_RP > EXIT_WAIT) ? T_RP : EXIT_WAIT;
  localparam int TW        = $clog2(TMAX1 + 1);
  localparam int BW        = $clog2(BURST_LEN + 1);
  localparam int GW        = $clog2(T_RFC + 1);

  state_e   state_q, state_d;
  purpose_e pur_q, pur_d;
  pdm_e     pdm_q, pdm_d;

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          bst_load, bst_zero;
  logic [BW-1:0] bst_val;
  logic          ref_due, any_open, grant;

  assign any_open = |bank_open_i;

  sdram_lp_tracker #(.T_REFI(T_REFI), .PEND_MAX(PEND_MAX)) tracker_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .freeze (state_q == ST_SR_HOLD),
    .served (state_q == ST_REF),
    .due    (ref_due)
  );

  sdram_lp_downcount #(.W(TW)) wait_tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (1'b1),
    .zero     (tmr_zero)
  );

  sdram_lp_downcount #(.W(BW)) burst_cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (bst_load),
    .load_val (bst_val),
    .dec      (state_q == ST_REF),
    .zero     (bst_zero)
  );

  always_comb begin
    state_d  = state_q;
    pur_d    = pur_q;
    pdm_d    = pdm_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    bst_load = 1'b0;
    bst_val  = '0;
    grant    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sr_enter_req_i) begin
          state_d = ST_PREP;
          pur_d   = PUR_SR_IN;
        end else if (ref_due) begin
          state_d = ST_PREP;
          pur_d   = PUR_REF;
        end else if (pd_enter_req_i) begin
          state_d = ST_PD;
          pdm_d   = any_open ? PDM_ACTIVE : PDM_PRECHG;
        end else begin
          grant = 1'b1;
        end
      end
      ST_PREP: begin
        bst_load = 1'b1;
        bst_val  = (pur_q == PUR_SR_IN) ? BW'(BURST_LEN) : BW'(1);
        state_d  = any_open ? ST_PRE : ST_REF;
      end
      ST_PRE: begin
        tmr_load = 1'b1;
        tmr_val  = TW'(T_RP - 2);
        state_d  = ST_WAIT_RP;
      end
      ST_WAIT_RP: begin
        if (tmr_zero) state_d = ST_REF;
      end
      ST_REF: begin
        tmr_load = 1'b1;
        tmr_val  = TW'(T_RFC - 2);
        state_d  = ST_WAIT_RFC;
      end
      ST_WAIT_RFC: begin
        if (tmr_zero) begin
          if (!bst_zero)             state_d = ST_REF;
          else if (pur_q == PUR_SR_IN) state_d = ST_SR_ENTER;
          else                       state_d = ST_IDLE;
        end
      end
      ST_SR_ENTER: state_d = ST_SR_HOLD;
      ST_SR_HOLD: begin
        if (sr_exit_req_i) begin
          state_d  = ST_SR_EXIT;
          tmr_load = 1'b1;
          tmr_val  = TW'(EXIT_WAIT - 1);
        end
      end
      ST_SR_EXIT: begin
        if (tmr_zero) begin
          state_d  = ST_REF;
          pur_d    = PUR_SR_OUT;
          bst_load = 1'b1;
          bst_val  = BW'(BURST_LEN);
        end
      end
      ST_PD: begin
        if (pd_exit_req_i) begin
          state_d  = ST_PD_EXIT;
          pdm_d    = PDM_NONE;
          tmr_load = 1'b1;
          tmr_val  = TW'(T_SS - 1);
        end
      end
      ST_PD_EXIT: begin
        if (tmr_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pur_q   <= PUR_REF;
      pdm_q   <= PDM_NONE;
    end else begin
      state_q <= state_d;
      pur_q   <= pur_d;
      pdm_q   <= pdm_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PRE:      cmd_o = CMD_PREA;
      ST_REF:      cmd_o = CMD_AREF;
      ST_SR_ENTER: cmd_o = CMD_SREF;
      default:     cmd_o = CMD_NOP;
    endcase
  end

  assign cke_o       = !((state_q == ST_SR_ENTER) || (state_q == ST_SR_HOLD) || (state_q == ST_PD));
  assign sr_active_o = (state_q == ST_SR_ENTER) || (state_q == ST_SR_HOLD);
  assign busy_o      = (state_q != ST_IDLE);
  assign grant_o     = grant;
  assign pd_mode_o   = pdm_q;

  // Gap counter since the last auto refresh, for the checker below.
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   gap_q <= GW'(T_RFC);
    else if (cmd_o == CMD_AREF)   gap_q <= GW'(1);
    else if (gap_q != GW'(T_RFC)) gap_q <= gap_q + GW'(1);
  end

  // R2
  rfc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != CMD_NOP) |-> (gap_q == GW'(T_RFC)));

  // R11
  cmd_nogrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != CMD_NOP) |-> !grant_o);

  // R11
  grant_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != CMD_NOP) |-> !$past(grant_o));

  // R1
  prea_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_PREA) |=> (cmd_o == CMD_NOP));

  // R4
  lowcke_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_o |-> ((cmd_o == CMD_NOP) || (cmd_o == CMD_SREF)));

  // R7
  pd_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode_o != PDM_NONE) |-> !cke_o);

  // R8
  cke_rise_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_o) |-> (cmd_o == CMD_NOP));

endmodule

// File: tb/sdram_lp_sequencer_tb_top.sv
`timescale 1ns/1ps
module sdram_lp_sequencer_tb_top;
  import sdram_lp_pkg::*;

  localparam int NB    = 4;
  localparam int TRP   = 3;
  localparam int TRFC  = 5;
  localparam int TSS   = 2;
  localparam int TREFI = 200;
  localparam int BLEN  = 4;
  localparam int PMAX  = 8;
  localparam int EXITW = (TRFC > TSS) ? TRFC : TSS;

  logic          clk, rst_n;
  logic [NB-1:0] bank_open;
  logic          sr_in, sr_out, pd_in, pd_out;
  logic [1:0]    cmd, pd_mode;
  logic          cke, grant, busy, sr_act;

  sdram_lp_sequencer #(
    .NUM_BANKS(NB), .T_RP(TRP), .T_RFC(TRFC), .T_SS(TSS),
    .T_REFI(TREFI), .BURST_LEN(BLEN), .PEND_MAX(PMAX)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bank_open_i(bank_open),
    .sr_enter_req_i(sr_in), .sr_exit_req_i(sr_out),
    .pd_enter_req_i(pd_in), .pd_exit_req_i(pd_out),
    .cmd_o(cmd), .cke_o(cke), .grant_o(grant), .busy_o(busy),
    .pd_mode_o(pd_mode), .sr_active_o(sr_act)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Bank model: stimulus posts a pattern, the monitor applies it and clears on precharge-all.
  logic [NB-1:0] open_val;
  int open_stb = 0, stb_seen = 0;
  logic [NB-1:0] bank_model = '0, prev_bank = '0, pd_snap = '0;
  assign bank_open = bank_model;

  int cyc = 0;
  int aref_total = 0, pre_total = 0, sref_total = 0;
  int last_aref = -1000, last_pre = -1000, rise_cyc = 0;
  bit rise_pend = 0, rise_sr = 0, prev_grant = 1, prev_cke = 1, prev_sr = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (open_stb != stb_seen) begin
        bank_model = open_val;
        stb_seen   = open_stb;
      end
      if (cmd != CMD_NOP) begin
        chk(!grant, "R11 grant in command cycle", grant, 0);
        chk(!prev_grant, "R11 grant before command", prev_grant, 0);
        chk(cyc - last_aref >= TRFC, "R2 gap after auto refresh", cyc - last_aref, TRFC);
        if (cmd == CMD_AREF || cmd == CMD_SREF) begin
          chk(bank_model == '0, "R1 bank open at refresh", bank_model, 0);
          chk(cyc - last_pre >= TRP, "R1 precharge to refresh gap", cyc - last_pre, TRP);
        end
        if (rise_pend) begin
          if (rise_sr) chk(cyc - rise_cyc >= EXITW, "R5 self-refresh exit wait", cyc - rise_cyc, EXITW);
          else         chk(cyc - rise_cyc >= TSS, "R8 power-down exit wait", cyc - rise_cyc, TSS);
          rise_pend = 0;
        end
        if (cmd == CMD_AREF) begin aref_total++; last_aref = cyc; end
        if (cmd == CMD_PREA) begin pre_total++; last_pre = cyc; bank_model = '0; end
        if (cmd == CMD_SREF) sref_total++;
      end
      if (!cke && cmd != CMD_NOP && cmd != CMD_SREF)
        chk(0, "R4 command while clock disabled", cmd, 0);
      if (cke && !prev_cke) begin
        rise_cyc = cyc; rise_pend = 1; rise_sr = prev_sr;
      end
      if (!cke && prev_cke && cmd != CMD_SREF) pd_snap = prev_bank;
      prev_grant = grant; prev_cke = cke; prev_sr = sr_act; prev_bank = bank_model;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic until_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic set_banks(input logic [NB-1:0] v);
    open_val = v;
    open_stb++;
    cycles(3);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int a0, p0, s0, hi;
    rst_n = 0; sr_in = 0; sr_out = 0; pd_in = 0; pd_out = 0; open_val = '0;
    cycles(4);
    // R11 reset state
    chk(cmd == CMD_NOP, "R11 reset command", cmd, 0);
    chk(cke == 1'b1, "R11 reset clock enable", cke, 1);
    chk(pd_mode == 2'd0, "R11 reset power-down mode", pd_mode, 0);
    rst_n = 1;
    cycles(2);
    chk(grant == 1'b1, "R11 grant when idle", grant, 1);

    // R9 one refresh after the first interval; R3 no precharge with banks closed
    until_cyc(230);
    chk(aref_total == 1, "R9 first interval refresh", aref_total, 1);
    chk(pre_total == 0, "R3 no precharge with banks closed", pre_total, 0);

    // R7 precharge power-down held long enough to saturate owed refreshes
    pd_in = 1;
    cycles(2);
    pd_in = 0;
    chk(cke == 1'b0, "R7 clock disabled in power-down", cke, 0);
    chk(pd_mode == 2'd2, "R7 precharge power-down", pd_mode, 2);
    chk(grant == 1'b0, "R11 no grant in power-down", grant, 0);
    until_cyc(2030);
    a0 = aref_total; p0 = pre_total;
    pd_out = 1; cycles(1); pd_out = 0;
    until_cyc(2150);
    chk(aref_total - a0 == PMAX, "R9 saturated owed refreshes", aref_total - a0, PMAX);
    chk(pre_total == p0, "R3 no precharge around refresh", pre_total - p0, 0);
    chk(grant == 1'b1, "R11 grant after refreshes", grant, 1);

    // R7 active power-down, then R1 precharge before the refresh owed meanwhile
    set_banks(4'b0010);
    pd_in = 1;
    cycles(2);
    pd_in = 0;
    chk(pd_mode == 2'd1, "R7 active power-down", pd_mode, 1);
    until_cyc(2230);
    a0 = aref_total; p0 = pre_total;
    pd_out = 1; cycles(1); pd_out = 0;
    until_cyc(2280);
    chk(pre_total - p0 == 1, "R1 precharge before refresh", pre_total - p0, 1);
    chk(aref_total - a0 == 1, "R9 owed refresh after power-down", aref_total - a0, 1);

    // R10 self refresh beats power-down; R6 bursts; R4 quiet hold
    set_banks(4'b1001);
    a0 = aref_total; p0 = pre_total; s0 = sref_total;
    sr_in = 1; pd_in = 1;
    for (int k = 0; k < 300 && sref_total == s0; k++) @(negedge clk);
    sr_in = 0; pd_in = 0;
    chk(sref_total - s0 == 1, "R10 self refresh chosen", sref_total - s0, 1);
    chk(aref_total - a0 == BLEN, "R6 burst before entry", aref_total - a0, BLEN);
    chk(pre_total - p0 == 1, "R1 precharge before self refresh", pre_total - p0, 1);
    cycles(1);
    chk(sr_act == 1'b1, "R4 self refresh flag", sr_act, 1);
    chk(pd_mode == 2'd0, "R10 power-down not taken", pd_mode, 0);
    hi = 0;
    for (int k = 0; k < 30; k++) begin
      if (cke) hi++;
      @(negedge clk);
    end
    chk(hi == 0, "R4 clock enable held low", hi, 0);
    a0 = aref_total;
    sr_out = 1; cycles(1); sr_out = 0;
    for (int k = 0; k < 300 && !grant; k++) @(negedge clk);
    chk(aref_total - a0 == BLEN, "R6 burst after exit", aref_total - a0, BLEN);
    chk(sr_act == 1'b0, "R4 self refresh flag cleared", sr_act, 0);

    // R7 sweep of every bank pattern into power-down
    for (int p = 0; p < (1 << NB); p++) begin
      set_banks(NB'(p));
      pd_in = 1;
      for (int k = 0; k < 60 && cke; k++) @(negedge clk);
      pd_in = 0;
      cycles(1);
      chk(pd_mode == ((pd_snap != '0) ? 2'd1 : 2'd2), "R7 mode from bank state",
          pd_mode, (pd_snap != '0) ? 1 : 2);
      pd_out = 1; cycles(1); pd_out = 0;
      cycles(TSS + 2);
      chk(pd_mode == 2'd0, "R7 mode cleared after exit", pd_mode, 0);
    end

    cycles(10);
    finish_run();
  end

endmodule